// File: doc/BRIEF.md
# Exception Entry Register Stacking Engine

This block performs the state-saving half of exception entry. When an exception request is accepted, it captures the eight caller-visible registers that an interrupted routine may lose, together with the current execution mode and stack-select bit. It chooses the active stack pointer, moves that pointer down by one 32-byte frame, and writes the eight words into that frame through a word-wide write port that can stall.

Once the last word has been written, the block produces a one-cycle done pulse. With that pulse it presents the new state for the register file and mode logic:

- both stack pointers, with only the chosen one lowered;
- a link-register return code that records the interrupted mode and stack;
- Handler mode with the main stack selected;
- a status word whose exception-number field carries the incoming exception.

Mode encoding is 1 for Handler and 0 for Thread. A stack-select value of 1 means the process stack.

Top module: `exc_stacker`

## Requirements
- R1: After reset, `mem_wr` and `done` are 0, and `lr_out`, `msp_out`, `psp_out`, `xpsr_out`, `mode_out` and `spsel_out` are all 0.
- R2: An accepted request produces exactly eight writes.
  - The writes go to byte addresses base+0, +4, +8, +12, +16, +20, +24 and +28, in that ascending order, where base is the chosen stack pointer minus 32.
  - Their data is r0, r1, r2, r3, r12, lr, pc and the status word, respectively.
  - pc is stored exactly as supplied.
- R3: The chosen stack is the main stack in Handler mode. In Thread mode it is the main stack when the select bit is 0 and the process stack when it is 1.
  - At done, the chosen pointer is output as base.
  - The other pointer is output unchanged.
- R4: The stored status word keeps bits 31:9 of `xpsr_in`. Its bits 8:0 are 0 when the interrupted mode is Thread, and equal `xpsr_in[8:0]` when it is Handler.
- R5: While `mem_wr` is 1 and `mem_ready` is 0, the next cycle still shows `mem_wr` at 1 with the same address and data.
- R6: At done, `lr_out` is 0xFFFFFFF1 for an interrupted Handler mode, 0xFFFFFFF9 for Thread on the main stack, and 0xFFFFFFFD for Thread on the process stack.
- R7: At done, `mode_out` is 1, `spsel_out` is 0, and `xpsr_out` equals `xpsr_in[31:9]` followed by the 9-bit zero-extended `exc_num`.
- R8: `done` is high for exactly one cycle. That cycle immediately follows the cycle in which the eighth word is accepted, and `mem_wr` is 0 during it.
- R9: A request raised while stacking is in progress has no effect. No further writes occur, and the outputs at done reflect only the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 1 | Exception request, sampled when idle |
| exc_num | input | NUM_W | Incoming exception number |
| r0 | input | 32 | Register r0 value |
| r1 | input | 32 | Register r1 value |
| r2 | input | 32 | Register r2 value |
| r3 | input | 32 | Register r3 value |
| r12 | input | 32 | Register r12 value |
| lr_in | input | 32 | Current link register |
| pc_in | input | 32 | Return or faulting instruction address |
| xpsr_in | input | 32 | Current status word |
| mode_in | input | 1 | Current mode, 1 = Handler |
| spsel_in | input | 1 | Current stack select, 1 = process stack |
| msp_in | input | AW | Current main stack pointer |
| psp_in | input | AW | Current process stack pointer |
| mem_wr | output | 1 | Write request |
| mem_addr | output | AW | Write byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Write accepted this cycle when high |
| done | output | 1 | One-cycle completion pulse |
| lr_out | output | 32 | New link register value |
| msp_out | output | AW | New main stack pointer |
| psp_out | output | AW | New process stack pointer |
| mode_out | output | 1 | New mode |
| spsel_out | output | 1 | New stack select |
| xpsr_out | output | 32 | New status word |

## Verification
A wrong word index or base address shows up at the write port on the very next accepted beat, as a write whose address or data does not match the expected frame entry. A corrupted captured mode or select bit stays hidden through all eight beats. It surfaces at the done pulse as the wrong stack pointer lowered, the wrong return code, or a wrong status field. A stray acceptance during stacking appears as surplus writes after the eighth beat, or as a done pulse out of place, within a cycle or two of completion.

// File: rtl/exc_stacker.sv
module exc_stacker #(
  parameter int NUM_W = 9,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_req,
  input  logic [NUM_W-1:0] exc_num,
  input  logic [31:0]      r0,
  input  logic [31:0]      r1,
  input  logic [31:0]      r2,
  input  logic [31:0]      r3,
  input  logic [31:0]      r12,
  input  logic [31:0]      lr_in,
  input  logic [31:0]      pc_in,
  input  logic [31:0]      xpsr_in,
  input  logic             mode_in,
  input  logic             spsel_in,
  input  logic [AW-1:0]    msp_in,
  input  logic [AW-1:0]    psp_in,
  output logic             mem_wr,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ready,
  output logic             done,
  output logic [31:0]      lr_out,
  output logic [AW-1:0]    msp_out,
  output logic [AW-1:0]    psp_out,
  output logic             mode_out,
  output logic             spsel_out,
  output logic [31:0]      xpsr_out
);
  localparam int WORDS    = 8;
  localparam int IDX_W    = $clog2(WORDS);
  localparam int IPSR_W   = 9;
  localparam int FRAME_B  = WORDS * 4;
  localparam logic [31:0] RET_HND = 32'hFFFF_FFF1;
  localparam logic [31:0] RET_MSP = 32'hFFFF_FFF9;
  localparam logic [31:0] RET_PSP = 32'hFFFF_FFFD;

  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [AW-1:0]     base;
  logic              mode_q, spsel_q;
  logic [NUM_W-1:0]  num_q;
  logic [AW-1:0]     msp_q, psp_q;
  logic [31:0]       xpsr_q;
  logic [31:0]       frame [WORDS];

  wire accept  = exc_req && !busy;
  wire use_psp = !mode_in && spsel_in;
  wire last    = busy && mem_ready && (idx == IDX_W'(WORDS - 1));
  wire q_psp   = !mode_q && spsel_q;

  assign mem_wr    = busy;
  assign mem_addr  = base + AW'({idx, 2'b00});
  assign mem_wdata = frame[idx];

  always_ff @(posedge clk) begin
    if (accept) begin
      frame[0] <= r0;
      frame[1] <= r1;
      frame[2] <= r2;
      frame[3] <= r3;
      frame[4] <= r12;
      frame[5] <= lr_in;
      frame[6] <= pc_in;
      frame[7] <= {xpsr_in[31:IPSR_W], mode_in ? xpsr_in[IPSR_W-1:0] : {IPSR_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      base    <= '0;
      mode_q  <= 1'b0;
      spsel_q <= 1'b0;
      num_q   <= '0;
      msp_q   <= '0;
      psp_q   <= '0;
      xpsr_q  <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      idx     <= '0;
      base    <= (use_psp ? psp_in : msp_in) - AW'(FRAME_B);
      mode_q  <= mode_in;
      spsel_q <= spsel_in;
      num_q   <= exc_num;
      msp_q   <= msp_in;
      psp_q   <= psp_in;
      xpsr_q  <= xpsr_in;
    end else if (busy && mem_ready) begin
      idx <= idx + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      lr_out    <= '0;
      msp_out   <= '0;
      psp_out   <= '0;
      mode_out  <= 1'b0;
      spsel_out <= 1'b0;
      xpsr_out  <= '0;
    end else begin
      done <= last;
      if (last) begin
        lr_out    <= mode_q ? RET_HND : (spsel_q ? RET_PSP : RET_MSP);
        msp_out   <= q_psp ? msp_q : base;
        psp_out   <= q_psp ? base  : psp_q;
        mode_out  <= 1'b1;
        spsel_out <= 1'b0;
        xpsr_out  <= {xpsr_q[31:IPSR_W], IPSR_W'(num_q)};
      end
    end
  end
endmodule

// File: rtl/exc_stacker_chk.sv
module exc_stacker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_wr,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          done,
  input logic [31:0]   lr_out,
  input logic          mode_out,
  input logic          spsel_out
);
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && !mem_ready |=> mem_wr && $stable(mem_addr) && $stable(mem_wdata));

  p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_addr[1:0] == 2'b00);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_wr);

  p_handler_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mode_out && !spsel_out);

  p_return_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lr_out == 32'hFFFF_FFF1 || lr_out == 32'hFFFF_FFF9 || lr_out == 32'hFFFF_FFFD);
endmodule

bind exc_stacker exc_stacker_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_wr(mem_wr), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .lr_out(lr_out),
  .mode_out(mode_out), .spsel_out(spsel_out)
);

// File: tb/exc_stacker_tb_top.sv
module exc_stacker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        exc_req = 1'b0;
  logic [8:0]  exc_num = '0;
  logic [31:0] r0 = '0, r1 = '0, r2 = '0, r3 = '0, r12 = '0, lr_in = '0, pc_in = '0, xpsr_in = '0;
  logic        mode_in = 1'b0, spsel_in = 1'b0;
  logic [31:0] msp_in = '0, psp_in = '0;
  logic        mem_wr, mem_ready, done, mode_out, spsel_out;
  logic [31:0] mem_addr, mem_wdata, lr_out, msp_out, psp_out, xpsr_out;

  exc_stacker dut_i (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_num(exc_num),
    .r0(r0), .r1(r1), .r2(r2), .r3(r3), .r12(r12), .lr_in(lr_in), .pc_in(pc_in),
    .xpsr_in(xpsr_in), .mode_in(mode_in), .spsel_in(spsel_in),
    .msp_in(msp_in), .psp_in(psp_in),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .done(done), .lr_out(lr_out), .msp_out(msp_out), .psp_out(psp_out),
    .mode_out(mode_out), .spsel_out(spsel_out), .xpsr_out(xpsr_out)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int pop_cyc = -10;
  bit stall_en = 1'b0;
  bit finished = 1'b0;
  logic [63:0] exp_q[$];
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // ready driver: changes 1 ns after each rising edge
  initial begin
    mem_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready = stall_en ? lfsr[0] : 1'b1;
    end
  end

  // monitor: compares each accepted write against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && mem_wr && mem_ready) begin
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R9 unexpected write actual=%08h expected=none", mem_addr);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        check("R2 addr", mem_addr, e[63:32]);
        check("R2 data", mem_wdata, e[31:0]);
        if (exp_q.size() == 0) pop_cyc = cyc;
      end
    end
  end

  task automatic run_exc(input bit mode, input bit sel, input logic [31:0] msp,
                         input logic [31:0] psp, input logic [8:0] num,
                         input logic [31:0] seed, input bit inject);
    logic [31:0] base, xs, exp_lr;
    bit upsp;
    int guard;
    upsp = !mode && sel;
    base = (upsp ? psp : msp) - 32'd32;
    xs = seed ^ 32'h0100_01A5;
    // R2/R4 expected frame
    exp_q.push_back({base + 32'd0,  seed + 32'd1});
    exp_q.push_back({base + 32'd4,  seed + 32'd2});
    exp_q.push_back({base + 32'd8,  seed + 32'd3});
    exp_q.push_back({base + 32'd12, seed + 32'd4});
    exp_q.push_back({base + 32'd16, seed + 32'd12});
    exp_q.push_back({base + 32'd20, seed + 32'd14});
    exp_q.push_back({base + 32'd24, seed + 32'd15});
    exp_q.push_back({base + 32'd28, {xs[31:9], mode ? xs[8:0] : 9'd0}});
    @(negedge clk);
    r0 = seed + 1; r1 = seed + 2; r2 = seed + 3; r3 = seed + 4; r12 = seed + 12;
    lr_in = seed + 14; pc_in = seed + 15; xpsr_in = xs;
    mode_in = mode; spsel_in = sel; msp_in = msp; psp_in = psp; exc_num = num;
    exc_req = 1'b1;
    @(negedge clk);
    exc_req = 1'b0;
    if (inject) begin
      // R9: requests while busy, with different inputs
      exc_num = num ^ 9'h0FF; mode_in = ~mode; spsel_in = ~sel;
      msp_in = msp ^ 32'h100; psp_in = psp ^ 32'h100; xpsr_in = ~xs;
      exc_req = 1'b1;
      repeat (3) @(negedge clk);
      exc_req = 1'b0;
    end
    guard = 0;
    while (!done && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    exp_lr = mode ? 32'hFFFF_FFF1 : (sel ? 32'hFFFF_FFFD : 32'hFFFF_FFF9);
    check("R8 done seen", {31'd0, done}, 32'd1);
    check("R8 done timing", cyc, pop_cyc + 1);
    check("R8 no write at done", {31'd0, mem_wr}, 32'd0);
    check("R2 all words written", exp_q.size(), 0);
    check("R6 lr code", lr_out, exp_lr);
    check("R3 msp", msp_out, upsp ? msp : base);
    check("R3 psp", psp_out, upsp ? base : psp);
    check("R7 mode/spsel", {30'd0, mode_out, spsel_out}, 32'd2);
    check("R7 xpsr_out", xpsr_out, {xs[31:9], num});
    @(negedge clk);
    check("R8 done one cycle", {31'd0, done}, 32'd0);
    repeat (3) begin
      check("R9 idle after done", {31'd0, mem_wr}, 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mem_wr", {31'd0, mem_wr}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 lr_out", lr_out, 32'd0);
    check("R1 sp", msp_out | psp_out, 32'd0);
    check("R1 xpsr/mode", xpsr_out | {30'd0, mode_out, spsel_out}, 32'd0);

    run_exc(1'b1, 1'b0, 32'h2000_1000, 32'h2000_8000, 9'd15,  32'h1000_0000, 1'b0);
    run_exc(1'b0, 1'b0, 32'h2000_2000, 32'h2000_9000, 9'd3,   32'h2200_0000, 1'b0);
    run_exc(1'b0, 1'b1, 32'h2000_3000, 32'h2000_A000, 9'd44,  32'h3300_0000, 1'b0);
    run_exc(1'b1, 1'b1, 32'h0000_0040, 32'h2000_B000, 9'd511, 32'h4400_0000, 1'b0);
    stall_en = 1'b1;
    run_exc(1'b0, 1'b1, 32'h2000_4000, 32'h2000_C000, 9'd17,  32'h5500_0000, 1'b0);
    run_exc(1'b1, 1'b0, 32'h2000_5000, 32'h2000_D000, 9'd2,   32'h6600_0000, 1'b1);
    stall_en = 1'b0;
    run_exc(1'b0, 1'b0, 32'h0000_0010, 32'h2000_E000, 9'd100, 32'h7700_0000, 1'b1);
    run_exc(1'b0, 1'b1, 32'h2000_6000, 32'h2000_F000, 9'd255, 32'h8800_0000, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule